// File: doc/BRIEF.md
# DVFS Level Transition Sequencer

This block steps a processor subsystem between five performance levels. A request names a target level; the sequencer compares it with the level in force and walks through an ordered transition. Supply rails are changed through a request/acknowledge channel to a regulator controller. The PLL is parked on an alternate source while the main divider word is rewritten. The memory-speed mode bits are set, and a refresh-rescale agent is told when the clocks have settled. One agent at a time is engaged, and the sequencer stalls on each acknowledge.

A sticky lock protects the level across sleep. A sleep request moves to the 800 MHz level and sets the lock. A wake request returns to the level saved at sleep and releases the lock. Ordinary requests carry two flag bits that can set or clear the lock themselves.

Top module: `dvfs_seq`

## Requirements
- R1: After reset `busy`, `done`, `err` and all request outputs are 0, `cur_level` is 1 (800 MHz), `mem_mode` is 00 and `pll_hi` is 0.
- R2: When the target level index is not above the current one (frequency up or equal), the sequencer issues a CPU rail request (`vreq_rail`=0) and then an internal rail request (`vreq_rail`=1) before any bypass or divider write. The CPU targets for levels 0..4 are 1250, 1200, 1050, 950 and 950 mV. The internal target is 1100 mV for levels 0..3 and 1000 mV for level 4.
- R3: When the frequency goes down, no rail request is made before the clock changes. After the refresh handshake, the internal rail is lowered first and then the CPU rail.
- R4: A request for the level already in force ends with a `done` pulse on the cycle after it is taken, with no other activity. The first accepted transition after reset always runs the full sequence.
- R5: For targets 0..3, `mem_mode` is written to 01 before the divider write. For target 4, `mem_mode` is left alone before the divider write and becomes 11 only after the divider busy bits have cleared.
- R6: The divider word is packed as [3:0] CPU divide, [7:4] system divide, [11:8] memory-bus divide and [15:12] peripheral divide. The words for levels 0..4 are 0x1440, 0x1330, 0x1131, 0x1033 and 0x0077. After the write strobe `div_we`, the sequencer waits until `div_busy[7:0]` is zero. `div_busy[15:8]` is ignored.
- R7: The PLL bypass handshake runs when the target PLL rate changes (level 0 at 1000 MHz, all others at 800 MHz) or on the first transition. Its away half (`byp_ret`=0) comes before the divider write and its return half (`byp_ret`=1) after it. At the return, `pll_hi` becomes 1 exactly when the target is level 0.
- R8: Every transition that is carried out makes one refresh-rescale request after all clock changes and before any rail is lowered.
- R9: `req_flags` bit 0 asks for the lock and bit 1 asks for release. When both bits are set, neither has any effect.
- R10: A release flag is applied before the lock is checked. A lock flag takes effect only after an accepted request, which still runs. A request made while the lock is held, without release, gets an `err` pulse and causes no activity.
- R11: A level above 4 gets an `err` pulse, causes no activity and leaves `cur_level` unchanged.
- R12: `sleep_req` saves the current level and requests level 1 with the lock flag. `wake_req` requests the saved level with the release flag.
- R13: `busy` is high from the cycle after a transition is accepted until `done`. `done` and `err` are single-cycle pulses and never occur together. `cur_level` takes the new value together with `done`.
- R14: Each of `vreq`, `byp_req` and `rfs_req` is a one-cycle pulse. The sequencer does not advance until the matching acknowledge arrives, however late.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Level request strobe |
| req_level | input | 3 | Requested level, 0 = fastest |
| req_flags | input | 2 | Bit 0 lock, bit 1 release |
| sleep_req | input | 1 | Sleep entry strobe |
| wake_req | input | 1 | Wake-up strobe |
| vreq | output | 1 | Regulator request pulse |
| vreq_rail | output | 1 | 0 = CPU rail, 1 = internal rail |
| vreq_mv | output | 11 | Rail target in millivolts |
| vack | input | 1 | Regulator acknowledge |
| byp_req | output | 1 | PLL bypass request pulse |
| byp_ret | output | 1 | 0 = switch away, 1 = return |
| byp_ack | input | 1 | Bypass acknowledge |
| rfs_req | output | 1 | Refresh-rescale request pulse |
| rfs_ack | input | 1 | Refresh-rescale acknowledge |
| div_word | output | 16 | Main divider word |
| div_we | output | 1 | Divider write strobe |
| div_busy | input | 16 | Divider busy status |
| mem_mode | output | 2 | Memory-speed mode field |
| pll_hi | output | 1 | PLL programmed to 1000 MHz |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Transition or no-op finished |
| err | output | 1 | Request rejected |
| cur_level | output | 3 | Level in force |

## Verification
Transitions are tried in every direction that matters:
- upward with a PLL change
- downward without one
- downward with one
- to and from the lowest level
- repeated to the same level

The order of handshakes, divider writes and mode changes is logged for each. The log separates the up and down rail orders, the two mode-bit placements and the presence or absence of the bypass. Flag patterns (none, lock, release, both), sleep/wake and an out-of-range level show whether the lock is taken before or after the check. A long regulator delay and busy bits set only in the upper status byte show whether the stall and the status mask are right.

// File: rtl/dvfs_pkg.sv
// dvfs_pkg: shared types and per-level tables for the DVFS sequencer.
// Assumes five levels, index 0 the fastest; tables are small case functions.
package dvfs_pkg;
    localparam int NUM_LEVELS = 5;
    localparam int LVL_W      = $clog2(NUM_LEVELS);
    localparam int MV_W       = 11;
    localparam int DIV_W      = 16;
    localparam logic [LVL_W-1:0] LOWEST = LVL_W'(NUM_LEVELS - 1);

    typedef enum logic [3:0] {
        S_IDLE, S_VUP_CPU, S_VUP_INT, S_BYP_AWAY, S_MODE_PRE, S_DIV_WR,
        S_DIV_WAIT, S_MODE_POST, S_BYP_RET, S_REFRESH, S_VDN_INT,
        S_VDN_CPU, S_FINISH
    } seq_state_t;

    function automatic logic [MV_W-1:0] cpu_mv(input logic [LVL_W-1:0] l);
        case (l)
            3'd0:    return MV_W'(1250);
            3'd1:    return MV_W'(1200);
            3'd2:    return MV_W'(1050);
            default: return MV_W'(950);
        endcase
    endfunction

    function automatic logic [MV_W-1:0] int_mv(input logic [LVL_W-1:0] l);
        return (l == LOWEST) ? MV_W'(1000) : MV_W'(1100);
    endfunction

    // Packing: [15:12] periph, [11:8] mem bus, [7:4] system, [3:0] CPU divide
    function automatic logic [DIV_W-1:0] div_of(input logic [LVL_W-1:0] l);
        case (l)
            3'd0:    return 16'h1440;
            3'd1:    return 16'h1330;
            3'd2:    return 16'h1131;
            3'd3:    return 16'h1033;
            default: return 16'h0077;
        endcase
    endfunction

    function automatic logic is_reg_st(input seq_state_t s);
        return s inside {S_VUP_CPU, S_VUP_INT, S_VDN_INT, S_VDN_CPU};
    endfunction

    function automatic logic is_byp_st(input seq_state_t s);
        return s inside {S_BYP_AWAY, S_BYP_RET};
    endfunction
endpackage

// File: rtl/dvfs_hs.sv
// dvfs_hs: one request/acknowledge channel. A one-cycle start yields a
// one-cycle req; fin pulses when ack arrives while a request is pending.
// Assumes the agent never acknowledges without an outstanding request.
module dvfs_hs (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic ack,
    output logic req,
    output logic fin
);
    logic pend_q;

    // Issue the request pulse and track the outstanding state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req    <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            req <= start;
            if (start)
                pend_q <= 1'b1;
            else if (ack)
                pend_q <= 1'b0;
        end
    end

    assign fin = pend_q & ack & ~start;

    // R14: request is a single-cycle pulse
    a_r14_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req);
endmodule

// File: rtl/dvfs_gate.sv
// dvfs_gate: admission and sticky lock. Release flag applies before the
// lock check, lock flag after an accepted request; both set means neither.
module dvfs_gate #(
    parameter int LW   = 3,
    parameter int NLVL = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          go,
    input  logic [1:0]    flags,
    input  logic [LW-1:0] level,
    output logic          accept,
    output logic          reject
);
    localparam logic [LW-1:0] TOP_IDX = LW'(NLVL - 1);
    logic lock_q, rel, lk, lock_eff;

    // Decode flags and decide on the request.
    always_comb begin
        rel      = (flags == 2'b10);
        lk       = (flags == 2'b01);
        lock_eff = lock_q & ~rel;
        reject   = go & (lock_eff | (level > TOP_IDX));
        accept   = go & ~reject;
    end

    // Update the sticky lock after each decision.
    always_ff @(posedge clk) begin
        if (!rst_n)
            lock_q <= 1'b0;
        else if (go)
            lock_q <= lock_eff | (accept & lk);
    end

    // R9: both flags set leave the lock unchanged
    a_r9_both_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (go && flags == 2'b11) |=> lock_q == $past(lock_q));
endmodule

// File: rtl/dvfs_seq.sv
// dvfs_seq: top of the DVFS level transition sequencer. Orders rail
// changes, PLL bypass, divider write, memory mode and refresh rescale.
// Assumes div_busy rises within one cycle of div_we.
module dvfs_seq
    import dvfs_pkg::*;
#(
    parameter int RESET_LEVEL = 1,
    parameter int SLEEP_LEVEL = 1,
    parameter int BUSY_W      = 16,
    parameter int CHK_W       = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [LVL_W-1:0]  req_level,
    input  logic [1:0]        req_flags,
    input  logic              sleep_req,
    input  logic              wake_req,
    output logic              vreq,
    output logic              vreq_rail,
    output logic [MV_W-1:0]   vreq_mv,
    input  logic              vack,
    output logic              byp_req,
    output logic              byp_ret,
    input  logic              byp_ack,
    output logic              rfs_req,
    input  logic              rfs_ack,
    output logic [DIV_W-1:0]  div_word,
    output logic              div_we,
    input  logic [BUSY_W-1:0] div_busy,
    output logic [1:0]        mem_mode,
    output logic              pll_hi,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [LVL_W-1:0]  cur_level
);
    seq_state_t state_q, nxt;
    logic [LVL_W-1:0] tgt_q, cur_q, saved_q, sel_lvl;
    logic [1:0] sel_flags;
    logic up_q, byp_q, first_q, kick_q, sel_go, accept, reject, byp_new;
    logic reg_fin, byp_fin, rfs_fin, settled;

    // Pick the pending request: sleep over wake over ordinary.
    always_comb begin
        sel_go    = (state_q == S_IDLE) & (sleep_req | wake_req | req_valid);
        sel_lvl   = sleep_req ? LVL_W'(SLEEP_LEVEL) : wake_req ? saved_q : req_level;
        sel_flags = sleep_req ? 2'b01 : wake_req ? 2'b10 : req_flags;
        byp_new   = first_q | ((sel_lvl == '0) != (cur_q == '0));
        settled   = (div_busy[CHK_W-1:0] == '0);
    end

    dvfs_gate #(.LW(LVL_W), .NLVL(NUM_LEVELS)) u_gate (
        .clk(clk), .rst_n(rst_n), .go(sel_go), .flags(sel_flags),
        .level(sel_lvl), .accept(accept), .reject(reject));

    dvfs_hs u_reg (.clk(clk), .rst_n(rst_n), .start(kick_q & is_reg_st(state_q)),
        .ack(vack), .req(vreq), .fin(reg_fin));
    dvfs_hs u_byp (.clk(clk), .rst_n(rst_n), .start(kick_q & is_byp_st(state_q)),
        .ack(byp_ack), .req(byp_req), .fin(byp_fin));
    dvfs_hs u_rfs (.clk(clk), .rst_n(rst_n), .start(kick_q & (state_q == S_REFRESH)),
        .ack(rfs_ack), .req(rfs_req), .fin(rfs_fin));

    // Next-state selection for the transition walk.
    always_comb begin
        nxt = state_q;
        case (state_q)
            S_IDLE:      if (accept && !(sel_lvl == cur_q && !first_q))
                             nxt = (sel_lvl <= cur_q) ? S_VUP_CPU :
                                   (byp_new ? S_BYP_AWAY : S_MODE_PRE);
            S_VUP_CPU:   if (reg_fin) nxt = S_VUP_INT;
            S_VUP_INT:   if (reg_fin) nxt = byp_q ? S_BYP_AWAY : S_MODE_PRE;
            S_BYP_AWAY:  if (byp_fin) nxt = S_MODE_PRE;
            S_MODE_PRE:  nxt = S_DIV_WR;
            S_DIV_WR:    nxt = S_DIV_WAIT;
            S_DIV_WAIT:  if (settled) nxt = S_MODE_POST;
            S_MODE_POST: nxt = byp_q ? S_BYP_RET : S_REFRESH;
            S_BYP_RET:   if (byp_fin) nxt = S_REFRESH;
            S_REFRESH:   if (rfs_fin) nxt = up_q ? S_FINISH : S_VDN_INT;
            S_VDN_INT:   if (reg_fin) nxt = S_VDN_CPU;
            S_VDN_CPU:   if (reg_fin) nxt = S_FINISH;
            default:     nxt = S_IDLE;
        endcase
    end

    // State, context registers and register-model outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= S_IDLE;
            kick_q   <= 1'b0;
            tgt_q    <= LVL_W'(RESET_LEVEL);
            cur_q    <= LVL_W'(RESET_LEVEL);
            saved_q  <= LVL_W'(RESET_LEVEL);
            up_q     <= 1'b0;
            byp_q    <= 1'b0;
            first_q  <= 1'b1;
            div_word <= '0;
            div_we   <= 1'b0;
            mem_mode <= 2'b00;
            pll_hi   <= 1'b0;
            done     <= 1'b0;
            err      <= 1'b0;
        end else begin
            state_q <= nxt;
            kick_q  <= (nxt != state_q) & (is_reg_st(nxt) | is_byp_st(nxt) | (nxt == S_REFRESH));
            div_we  <= (state_q == S_DIV_WR);
            done    <= 1'b0;
            err     <= reject;
            if (state_q == S_IDLE && accept) begin
                tgt_q <= sel_lvl;
                up_q  <= (sel_lvl <= cur_q);
                byp_q <= byp_new;
                if (sleep_req) saved_q <= cur_q;
                if (sel_lvl == cur_q && !first_q) done <= 1'b1;
            end
            if (state_q == S_MODE_PRE && tgt_q != LOWEST) mem_mode <= 2'b01;
            if (state_q == S_DIV_WR) div_word <= div_of(tgt_q);
            if (state_q == S_MODE_POST) begin
                if (tgt_q == LOWEST) mem_mode <= 2'b11;
                if (byp_q) pll_hi <= (tgt_q == '0);
            end
            if (state_q == S_FINISH) begin
                cur_q   <= tgt_q;
                first_q <= 1'b0;
                done    <= 1'b1;
            end
        end
    end

    assign vreq_rail = (state_q == S_VUP_INT) | (state_q == S_VDN_INT);
    assign vreq_mv   = vreq_rail ? int_mv(tgt_q) : cpu_mv(tgt_q);
    assign byp_ret   = (state_q == S_BYP_RET);
    assign busy      = (state_q != S_IDLE);
    assign cur_level = cur_q;

    // R13: done and err are exclusive and single-cycle
    a_r13_no_done_err: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    a_r13_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6: no progress while a checked busy bit is set
    a_r6_hold_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DIV_WAIT && !settled) |=> state_q == S_DIV_WAIT);
    // R10 / R11: a rejected request is flagged and starts nothing
    a_r10_reject_err: assert property (@(posedge clk) disable iff (!rst_n)
        reject |=> (err && !busy));
    // R2: no rail request while the divider settles
    a_r2_quiet_div: assert property (@(posedge clk) disable iff (!rst_n)
        div_we |-> !vreq);
endmodule

// File: tb/sim_dvfs_seq.sv
module sim_dvfs_seq;
    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 0, sleep_req = 0, wake_req = 0;
    logic [2:0] req_level = 0;
    logic [1:0] req_flags = 0;
    logic vreq, vreq_rail, vack, byp_req, byp_ret, byp_ack, rfs_req, rfs_ack;
    logic [10:0] vreq_mv;
    logic [15:0] div_word, div_busy;
    logic div_we, pll_hi, busy, done, err;
    logic [1:0] mem_mode;
    logic [2:0] cur_level;

    int n_chk = 0, n_bad = 0, dly = 2, max_w = 0, last_cpu = 0, last_int = 0, mode_busy = 0;
    bit hi_only = 0, busy_drop = 0, got_done = 0, got_err = 0, hi_at_done = 0;
    logic [15:0] w_word;
    logic [1:0] w_mode;
    string ev = "";

    always #5 clk = ~clk;

    dvfs_seq u0 (.clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_level(req_level),
        .req_flags(req_flags), .sleep_req(sleep_req), .wake_req(wake_req),
        .vreq(vreq), .vreq_rail(vreq_rail), .vreq_mv(vreq_mv), .vack(vack),
        .byp_req(byp_req), .byp_ret(byp_ret), .byp_ack(byp_ack),
        .rfs_req(rfs_req), .rfs_ack(rfs_ack), .div_word(div_word), .div_we(div_we),
        .div_busy(div_busy), .mem_mode(mem_mode), .pll_hi(pll_hi), .busy(busy),
        .done(done), .err(err), .cur_level(cur_level));

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chks(input string tag, input string act, input string exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual \"%s\" expected \"%s\"", tag, act, exp);
        end
    endtask

    // event log: C/I rail req, A/R bypass, W divider write, F refresh, M mode change
    initial begin : monitor
        int w;
        logic [1:0] pm;
        w = 0; pm = 2'b00;
        forever begin
            @(negedge clk);
            if (rst_n) begin
                if (vreq) begin
                    w++;
                    if (w == 1) begin
                        ev = {ev, vreq_rail ? "I" : "C"};
                        if (vreq_rail) last_int = vreq_mv; else last_cpu = vreq_mv;
                    end
                end else w = 0;
                if (w > max_w) max_w = w;
                if (byp_req) ev = {ev, byp_ret ? "R" : "A"};
                if (div_we) begin ev = {ev, "W"}; w_word = div_word; w_mode = mem_mode; end
                if (rfs_req) ev = {ev, "F"};
                if (mem_mode != pm) begin ev = {ev, "M"}; mode_busy = div_busy[7:0]; end
                pm = mem_mode;
            end
        end
    end

    initial begin : reg_agent
        vack = 0;
        forever begin
            @(negedge clk);
            if (vreq) begin
                repeat (dly) @(negedge clk);
                vack = 1; @(negedge clk); vack = 0;
            end
        end
    end

    initial begin : byp_agent
        byp_ack = 0;
        forever begin
            @(negedge clk);
            if (byp_req) begin
                repeat (2) @(negedge clk);
                byp_ack = 1; @(negedge clk); byp_ack = 0;
            end
        end
    end

    initial begin : rfs_agent
        rfs_ack = 0;
        forever begin
            @(negedge clk);
            if (rfs_req) begin
                @(negedge clk);
                rfs_ack = 1; @(negedge clk); rfs_ack = 0;
            end
        end
    end

    initial begin : div_agent
        div_busy = '0;
        forever begin
            @(negedge clk);
            if (div_we) begin
                if (hi_only) begin
                    div_busy = 16'hFF00; repeat (40) @(negedge clk);
                end else begin
                    div_busy = 16'h0081; repeat (3) @(negedge clk);
                end
                div_busy = '0;
            end
        end
    end

    // kind 0 ordinary, 1 sleep, 2 wake
    task automatic go(input int kind, input logic [2:0] lvl, input logic [1:0] fl);
        ev = ""; busy_drop = 0;
        @(negedge clk);
        case (kind)
            1: sleep_req = 1;
            2: wake_req = 1;
            default: begin req_valid = 1; req_level = lvl; req_flags = fl; end
        endcase
        @(negedge clk);
        req_valid = 0; sleep_req = 0; wake_req = 0; req_flags = 0;
        for (int i = 0; i < 3000; i++) begin
            if (done || err) break;
            if (!busy) busy_drop = 1;
            @(negedge clk);
        end
        got_done = done; got_err = err; hi_at_done = |div_busy[15:8];
        if (!(done || err)) chk("R13 completion timeout", 0, 1);
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        chk("R1 busy", busy, 0);
        chk("R1 cur_level", cur_level, 1);
        chk("R1 mem_mode", mem_mode, 0);
        chk("R1 pll_hi", pll_hi, 0);
        chk("R1 done/err/vreq", {done, err, vreq, byp_req, rfs_req}, 0);
    endtask

    task automatic t_first;
        go(0, 3'd1, 2'b00);
        chks("R4 first run full sequence", ev, "CIAMWRF");
        chk("R2 cpu mv L1", last_cpu, 1200);
        chk("R2 int mv L1", last_int, 1100);
        chk("R6 word L1", w_word, 16'h1330);
        chk("R5 mode 01 before write", w_mode, 1);
        chk("R13 done", got_done, 1);
        chk("R13 busy held", busy_drop, 0);
    endtask

    task automatic t_same;
        go(0, 3'd1, 2'b00);
        chks("R4 same level no activity", ev, "");
        chk("R4 done", got_done, 1);
    endtask

    task automatic t_lowest;
        go(0, 3'd4, 2'b00);
        chks("R3 down order to L4", ev, "WMFIC");
        chk("R3 int mv L4", last_int, 1000);
        chk("R3 cpu mv L4", last_cpu, 950);
        chk("R6 word L4", w_word, 16'h0077);
        chk("R5 mode untouched before write", w_mode, 1);
        chk("R5 mode 11 after", mem_mode, 3);
        chk("R5 R6 mode set after busy clear", mode_busy, 0);
        chk("R13 cur_level", cur_level, 4);
    endtask

    task automatic t_top;
        go(0, 3'd0, 2'b00);
        chks("R2 R7 up with bypass", ev, "CIAMWRF");
        chk("R2 cpu mv L0", last_cpu, 1250);
        chk("R6 word L0", w_word, 16'h1440);
        chk("R7 pll_hi set", pll_hi, 1);
        chk("R5 mode 01", mem_mode, 1);
    endtask

    task automatic t_hi_busy;
        hi_only = 1;
        go(0, 3'd2, 2'b00);
        hi_only = 0;
        chks("R7 R8 down with bypass", ev, "AWRFIC");
        chk("R3 cpu mv L2", last_cpu, 1050);
        chk("R7 pll_hi cleared", pll_hi, 0);
        chk("R6 upper busy ignored", hi_at_done, 1);
        repeat (45) @(negedge clk);
    endtask

    task automatic t_invalid;
        go(0, 3'd5, 2'b00);
        chk("R11 err", got_err, 1);
        chks("R11 no activity", ev, "");
        chk("R11 level kept", cur_level, 2);
    endtask

    task automatic t_both;
        go(0, 3'd3, 2'b11);
        chks("R9 both flags run", ev, "WFIC");
        go(0, 3'd2, 2'b00);
        chk("R9 not locked", got_done, 1);
        chks("R9 next accepted", ev, "CIWF");
    endtask

    task automatic t_lock;
        go(0, 3'd3, 2'b01);
        chks("R10 locking request runs", ev, "WFIC");
        go(0, 3'd2, 2'b00);
        chk("R10 locked err", got_err, 1);
        chks("R10 locked no activity", ev, "");
        chk("R10 level kept", cur_level, 3);
        go(0, 3'd2, 2'b10);
        chk("R10 release before check", got_done, 1);
        chks("R10 released run", ev, "CIWF");
    endtask

    task automatic t_sleep;
        go(1, 3'd0, 2'b00);
        chks("R12 sleep to L1", ev, "CIWF");
        chk("R12 sleep level", cur_level, 1);
        go(0, 3'd3, 2'b00);
        chk("R12 locked in sleep", got_err, 1);
        go(2, 3'd0, 2'b00);
        chks("R12 wake restores", ev, "WFIC");
        chk("R12 wake level", cur_level, 2);
        go(0, 3'd3, 2'b00);
        chk("R12 unlocked after wake", got_done, 1);
    endtask

    task automatic t_stall;
        dly = 12; max_w = 0;
        go(0, 3'd0, 2'b00);
        dly = 2;
        chks("R14 stalled sequence", ev, "CIAWRF");
        chk("R14 busy kept through stall", busy_drop, 0);
        chk("R14 req width", max_w, 1);
        chk("R8 R13 final level", cur_level, 0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset;
        t_first;
        t_same;
        t_lowest;
        t_top;
        t_hi_busy;
        t_invalid;
        t_both;
        t_lock;
        t_sleep;
        t_stall;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule